// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Generation

This block performs the seven shift and rotate operations of an x86-compatible integer core on one operand, in byte or word width. Each operation takes an operand, a count, an operation code and the incoming status flags, and returns the shifted or rotated value together with an updated flag word. Decode, operand fetch and writeback belong to the surrounding pipeline; this unit is only the datapath and its flag logic.

The inputs are captured in an input register. The datapath between that register and a registered output is purely combinational, so a new operation can be issued on every clock and each result appears two clocks after its inputs. Only the low five bits of the count are used. A reduced count of zero leaves the value unchanged and keeps the incoming carry. Rotates through carry treat the carry as one more bit of the rotated word. Overflow uses one formula for left operations and another for right operations.

Top module: `shrot_unit`

## Requirements
- R1: Inputs sampled at a rising edge produce their result and flags at the outputs after the following rising edge (two-cycle latency, one new operation per cycle). While rst is high, result_out and flags_out are zero after the next edge. Flag word bit positions are CF bit 0, PF bit 1, AF bit 2, ZF bit 3, SF bit 4 and OF bit 5 (flags_in carries bits 0 to 4).
- R2: Only count_in[4:0] is used and the upper count bits have no effect. When count_in[4:0] is zero the result equals the operand (within the selected width) and CF equals the incoming CF.
- R3: For a non-zero reduced count, CF is the last bit moved out. For SHL and SHR with a count above the width it is 0. For SAR with a count above the width it is the operand sign bit.
- R4: The rotates (op 0 to 3) leave AF, PF, SF and ZF equal to their incoming values.
- R5: For ROL, RCL and SHL (op 0, 2, 4, 7), OF is the XOR of the outgoing CF and the result's most significant bit (bit 7 or 15).
- R6: For ROR, RCR, SHR and SAR (op 1, 3, 5, 6), OF is the XOR of result bits 7 and 6 (byte) or 15 and 14 (word).
- R7: SHL, SHR and SAR clear AF. They set SF to the result MSB and ZF when the result within the width is zero. They set PF when result bits 7:0 hold an even number of ones.
- R8: RCL and RCR rotate the (width+1)-bit value formed by CF and the operand. A reduced count equal to width+1 returns the operand and CF unchanged.
- R9: ROL and ROR rotate modulo the width. A count equal to the width returns the operand, and CF is then result bit 0 for ROL or the result MSB for ROR.
- R10: SHL and SHR fill with zeros and SAR fills with the sign bit. A count of at least the width gives zero for SHL and SHR, and all sign bits for SAR.
- R11: wide_in = 1 selects 16-bit width and wide_in = 0 selects 8-bit width. In 8-bit mode operand bits 15:8 are ignored and result bits 15:8 are zero.
- R12: Operation codes are 0 ROL, 1 ROR, 2 RCL, 3 RCR, 4 SHL, 5 SHR, 6 SAR. Code 7 behaves exactly as SHL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opnd_in | input | 16 | Operand to shift or rotate |
| wide_in | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| count_in | input | 8 | Shift count, low 5 bits used |
| op_in | input | 3 | Operation code |
| flags_in | input | 5 | Incoming CF, PF, AF, ZF, SF |
| result_out | output | 16 | Registered result |
| flags_out | output | 6 | Registered outgoing flag word |

## Verification
The properties assume that rst is held for at least one edge before operations start. They also assume that each result is judged against the operation, width, count and flags presented two edges earlier, so a checker-side counter keeps them quiet until two edges after reset release. The stimulus meets these conditions: it resets first and then issues one operation per clock. It sweeps every operation code, both widths and all 32 reduced counts, and places random values in the unused count bits, the upper operand byte and the incoming flags, so the ignored inputs are exercised on every cycle.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAR = 3'd6,
    OP_SAL = 3'd7
  } shrot_op_e;

  // flag word bit positions
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;
  localparam int FL_W  = 6;
  localparam int FL_IN_W = 5;

  function automatic logic op_is_rot(input shrot_op_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction

  function automatic logic op_is_left(input shrot_op_e op);
    return (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SAL);
  endfunction

endpackage

// File: rtl/shrot_lane.sv
// One width lane: result and outgoing carry for a fixed operand width.
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W      = 8,
  parameter int CNT_IN = 8
) (
  input  logic [W-1:0]      x,
  input  logic [CNT_IN-1:0] cnt,
  input  shrot_op_e         op,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic              cout
);

  localparam int EW  = W + 1;
  localparam int NEED = $clog2(2 * EW + 1);
  localparam int AW  = (NEED > CNT_IN) ? NEED : CNT_IN;

  logic [AW-1:0] amt;
  logic [AW-1:0] n_rot;
  logic [AW-1:0] n_rc;
  logic [EW-1:0] ext;

  assign amt   = AW'(cnt);
  assign n_rot = amt % AW'(W);
  assign n_rc  = amt % AW'(EW);
  assign ext   = {cin, x};

  logic [W-1:0]  rol_v;
  logic [W-1:0]  ror_v;
  logic [EW-1:0] rcl_v;
  logic [EW-1:0] rcr_v;
  logic [EW-1:0] shl_v;
  logic [EW-1:0] shr_v;
  logic [EW-1:0] sar_v;

  // plain rotates: double the word and take a window
  assign rol_v = W'(({x, x} << n_rot) >> W);
  assign ror_v = W'({x, x} >> n_rot);

  // rotates through carry: window over the doubled (W+1)-bit word
  assign rcl_v = EW'(({ext, ext} << n_rc) >> EW);
  assign rcr_v = EW'({ext, ext} >> n_rc);

  // shifts: keep one extra bit beside the result for the carry
  assign shl_v = EW'({{W{1'b0}}, x} << amt);
  assign shr_v = EW'(({x, {W{1'b0}}} >> amt) >> (W - 1));
  assign sar_v = EW'(($signed({x, {W{1'b0}}}) >>> amt) >>> (W - 1));

  logic c_raw;

  always_comb begin
    res   = x;
    c_raw = cin;
    unique case (op)
      OP_ROL: begin res = rol_v; c_raw = rol_v[0];   end
      OP_ROR: begin res = ror_v; c_raw = ror_v[W-1]; end
      OP_RCL: begin res = rcl_v[W-1:0]; c_raw = rcl_v[W]; end
      OP_RCR: begin res = rcr_v[W-1:0]; c_raw = rcr_v[W]; end
      OP_SHR: begin res = shr_v[W:1]; c_raw = shr_v[0]; end
      OP_SAR: begin res = sar_v[W:1]; c_raw = sar_v[0]; end
      default: begin res = shl_v[W-1:0]; c_raw = shl_v[W]; end
    endcase
  end

  // a zero count moves nothing, so carry stays as it came in
  assign cout = (amt == '0) ? cin : c_raw;

endmodule

// File: rtl/shrot_flags.sv
// Flag word composition from the selected lane.
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]  res,
  input  logic               wide,
  input  shrot_op_e          op,
  input  logic               cout,
  input  logic [FL_IN_W-1:1] keep,
  output logic [FL_W-1:0]    fout
);

  localparam int NW = DATA_W / 2;

  logic msb;
  logic nxt;
  logic zero;
  logic par_even;

  assign msb      = wide ? res[DATA_W-1] : res[NW-1];
  assign nxt      = wide ? res[DATA_W-2] : res[NW-2];
  assign zero     = wide ? (res == '0) : (res[NW-1:0] == '0);
  assign par_even = ~^res[7:0];

  always_comb begin
    fout              = '0;
    fout[FL_IN_W-1:1] = keep;
    fout[FL_CF]       = cout;
    fout[FL_OF]       = op_is_left(op) ? (cout ^ msb) : (msb ^ nxt);
    if (!op_is_rot(op)) begin
      fout[FL_AF] = 1'b0;
      fout[FL_PF] = par_even;
      fout[FL_SF] = msb;
      fout[FL_ZF] = zero;
    end
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    opnd_in,
  input  logic                 wide_in,
  input  logic [CNT_IN_W-1:0]  count_in,
  input  logic [2:0]           op_in,
  input  logic [FL_IN_W-1:0]   flags_in,
  output logic [DATA_W-1:0]    result_out,
  output logic [FL_W-1:0]      flags_out
);

  localparam int NW      = DATA_W / 2;
  localparam int N_LANES = 2;
  localparam logic [CNT_IN_W-1:0] CNT_MASK = CNT_IN_W'((1 << CNT_W) - 1);

  // input register
  logic [DATA_W-1:0]   x_q;
  logic                wide_q;
  logic [CNT_IN_W-1:0] cnt_q;
  shrot_op_e           op_q;
  logic [FL_IN_W-1:0]  fl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      wide_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_ROL;
      fl_q   <= '0;
    end else begin
      x_q    <= opnd_in;
      wide_q <= wide_in;
      cnt_q  <= count_in & CNT_MASK;
      op_q   <= shrot_op_e'(op_in);
      fl_q   <= flags_in;
    end
  end

  // one lane per supported width
  logic [DATA_W-1:0] lane_res [N_LANES];
  logic              lane_c   [N_LANES];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NW : DATA_W;
    logic [LW-1:0] lres;
    logic          lc;
    shrot_lane #(.W(LW), .CNT_IN(CNT_IN_W)) u_lane (
      .x    (x_q[LW-1:0]),
      .cnt  (cnt_q),
      .op   (op_q),
      .cin  (fl_q[FL_CF]),
      .res  (lres),
      .cout (lc)
    );
    assign lane_res[g] = DATA_W'(lres);
    assign lane_c[g]   = lc;
  end

  logic [DATA_W-1:0] res_d;
  logic              c_d;
  logic [FL_W-1:0]   fl_d;

  assign res_d = wide_q ? lane_res[1] : lane_res[0];
  assign c_d   = wide_q ? lane_c[1]   : lane_c[0];

  shrot_flags #(.DATA_W(DATA_W)) u_flags (
    .res  (res_d),
    .wide (wide_q),
    .op   (op_q),
    .cout (c_d),
    .keep (fl_q[FL_IN_W-1:1]),
    .fout (fl_d)
  );

  // output register
  always_ff @(posedge clk) begin
    if (rst) begin
      result_out <= '0;
      flags_out  <= '0;
    end else begin
      result_out <= res_d;
      flags_out  <= fl_d;
    end
  end

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
  import shrot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [DATA_W-1:0]   opnd_in,
  input logic                wide_in,
  input logic [CNT_W-1:0]    cnt_lo,
  input logic [2:0]          op_in,
  input logic [FL_IN_W-1:0]  flags_in,
  input logic [DATA_W-1:0]   result_out,
  input logic [FL_W-1:0]     flags_out
);

  localparam int NW = DATA_W / 2;

  // inputs delayed to line up with the outputs they produce
  logic [DATA_W-1:0]  x_d1, x_d2;
  logic               w_d1, w_d2;
  logic [CNT_W-1:0]   c_d1, c_d2;
  logic [2:0]         o_d1, o_d2;
  logic [FL_IN_W-1:0] f_d1, f_d2;
  logic [1:0]         up;

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= '0;
    end else if (up != 2'd2) begin
      up <= up + 2'd1;
    end
    x_d1 <= opnd_in;  x_d2 <= x_d1;
    w_d1 <= wide_in;  w_d2 <= w_d1;
    c_d1 <= cnt_lo;   c_d2 <= c_d1;
    o_d1 <= op_in;    o_d2 <= o_d1;
    f_d1 <= flags_in; f_d2 <= f_d1;
  end

  logic armed;
  logic msb_o;
  logic nxt_o;
  logic rot2;
  logic left2;
  logic logic_sh2;
  logic [DATA_W-1:0] x_w2;
  logic [5:0] width2;

  assign armed     = (up == 2'd2);
  assign msb_o     = w_d2 ? result_out[DATA_W-1] : result_out[NW-1];
  assign nxt_o     = w_d2 ? result_out[DATA_W-2] : result_out[NW-2];
  assign rot2      = (o_d2[2] == 1'b0);
  assign left2     = (o_d2 == 3'd0) || (o_d2 == 3'd2) || (o_d2 == 3'd4) || (o_d2 == 3'd7);
  assign logic_sh2 = (o_d2 == 3'd4) || (o_d2 == 3'd5) || (o_d2 == 3'd7);
  assign x_w2      = w_d2 ? x_d2 : DATA_W'(x_d2[NW-1:0]);
  assign width2    = w_d2 ? 6'(DATA_W) : 6'(NW);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result_out == '0) && (flags_out == '0));

  p_zero_count_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && (c_d2 == '0)) |-> (result_out == x_w2) && (flags_out[FL_CF] == f_d2[FL_CF]));

  p_rot_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && rot2) |-> (flags_out[FL_SF:FL_PF] == f_d2[FL_SF:FL_PF]));

  p_left_of_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && left2) |-> (flags_out[FL_OF] == (flags_out[FL_CF] ^ msb_o)));

  p_right_of_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && !left2) |-> (flags_out[FL_OF] == (msb_o ^ nxt_o)));

  p_shift_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && !rot2) |-> (!flags_out[FL_AF] && (flags_out[FL_SF] == msb_o)));

  p_wide_count_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && logic_sh2 && (6'(c_d2) >= width2)) |-> (result_out == '0));

  p_narrow_upper_r11: assert property (@(posedge clk) disable iff (rst)
    (armed && !w_d2) |-> (result_out[DATA_W-1:NW] == '0));

endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opnd_in    (opnd_in),
  .wide_in    (wide_in),
  .cnt_lo     (count_in[CNT_W-1:0]),
  .op_in      (op_in),
  .flags_in   (flags_in),
  .result_out (result_out),
  .flags_out  (flags_out)
);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] opnd_in;
  logic        wide_in;
  logic [7:0]  count_in;
  logic [2:0]  op_in;
  logic [4:0]  flags_in;
  logic [15:0] result_out;
  logic [5:0]  flags_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst(rst), .opnd_in(opnd_in), .wide_in(wide_in),
    .count_in(count_in), .op_in(op_in), .flags_in(flags_in),
    .result_out(result_out), .flags_out(flags_out)
  );

  typedef struct {
    logic [15:0] res;
    logic [5:0]  fl;
    int          op;
    bit          wide;
    int          cm;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // step-by-step behavioural model
  function automatic exp_t model(input int op, input bit wide, input int x,
                                 input int craw, input logic [4:0] fin);
    exp_t e;
    int   w    = wide ? 16 : 8;
    int   mask = (1 << w) - 1;
    int   v    = x & mask;
    int   c    = craw & 31;
    int   ones = 0;
    int   b;
    int   msb;
    int   nxt;
    int   cf   = int'(fin[0]);
    for (int k = 0; k < c; k++) begin
      msb = (v >> (w - 1)) & 1;
      b   = v & 1;
      case (op)
        0: begin cf = msb; v = ((v << 1) | msb) & mask; end
        1: begin cf = b;   v = (v >> 1) | (b << (w - 1)); end
        2: begin v = ((v << 1) | cf) & mask; cf = msb; end
        3: begin v = (v >> 1) | (cf << (w - 1)); cf = b; end
        5: begin cf = b;   v = v >> 1; end
        6: begin cf = b;   v = (v >> 1) | (msb << (w - 1)); end
        default: begin cf = msb; v = (v << 1) & mask; end
      endcase
    end
    msb = (v >> (w - 1)) & 1;
    nxt = (v >> (w - 2)) & 1;
    e.fl = {1'b0, fin};
    e.fl[0] = cf[0];
    if (op == 0 || op == 2 || op == 4 || op == 7) e.fl[5] = cf[0] ^ msb[0];
    else                                          e.fl[5] = msb[0] ^ nxt[0];
    if (op >= 4) begin
      for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
      e.fl[2] = 1'b0;
      e.fl[4] = msb[0];
      e.fl[3] = (v == 0);
      e.fl[1] = ((ones % 2) == 0);
    end
    e.res  = v[15:0];
    e.op   = op;
    e.wide = wide;
    e.cm   = c;
    return e;
  endfunction

  task automatic compare_due();
    exp_t  e;
    string rt;
    bit    rot;
    if (exp_q.size() == 2) begin
      e   = exp_q.pop_front();
      rot = (e.op < 4);
      if (e.cm == 0)                  rt = "R2";
      else if (e.op == 7)             rt = "R12";
      else if (e.op == 2 || e.op == 3) rt = "R8";
      else if (rot)                   rt = "R9";
      else                            rt = "R10";
      chk(rt, "result", int'(result_out), int'(e.res));
      if (!e.wide) chk("R11", "upper byte", int'(result_out[15:8]), 0);
      chk((e.cm == 0) ? "R2" : "R3", "CF", int'(flags_out[0]), int'(e.fl[0]));
      chk((e.op == 0 || e.op == 2 || e.op == 4 || e.op == 7) ? "R5" : "R6",
          "OF", int'(flags_out[5]), int'(e.fl[5]));
      chk(rot ? "R4" : "R7", "AF", int'(flags_out[2]), int'(e.fl[2]));
      chk(rot ? "R4" : "R7", "PF", int'(flags_out[1]), int'(e.fl[1]));
      chk(rot ? "R4" : "R7", "SF", int'(flags_out[4]), int'(e.fl[4]));
      chk(rot ? "R4" : "R7", "ZF", int'(flags_out[3]), int'(e.fl[3]));
    end
  endtask

  int pats [6];

  initial begin
    rst = 1'b1; opnd_in = '0; wide_in = 1'b0; count_in = '0; op_in = '0; flags_in = '0;
    pats[0] = 32'h0000; pats[1] = 32'hFFFF; pats[2] = 32'h8001; pats[3] = 32'h5A3C;
    pats[4] = int'($urandom & 32'hFFFF); pats[5] = int'($urandom & 32'hFFFF);
    opnd_in = 16'hBEEF; op_in = 3'd6; count_in = 8'd3; flags_in = 5'h1F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset result", int'(result_out), 0);
    chk("R1", "reset flags", int'(flags_out), 0);
    rst = 1'b0;
    for (int p = 0; p < 6; p++) begin
      for (int cf = 0; cf < 2; cf++) begin
        for (int op = 0; op < 8; op++) begin
          for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 32; c++) begin
              if (p != 0 || cf != 0 || op != 0 || w != 0 || c != 0) @(negedge clk);
              compare_due();
              opnd_in  = pats[p][15:0];
              if (w == 0) opnd_in[15:8] = 8'($urandom);
              wide_in  = w[0];
              count_in = {3'($urandom), c[4:0]};
              op_in    = op[2:0];
              flags_in = 5'($urandom);
              flags_in[0] = cf[0];
              exp_q.push_back(model(op, w[0], int'(opnd_in), int'(count_in), flags_in));
            end
          end
        end
      end
    end
    repeat (2) begin
      @(negedge clk);
      compare_due();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule